// File: doc/BRIEF.md
# Sinusoidal PWM Half-Cycle Generator

The block drives the two legs of a single-phase bridge with pulse-width-modulated gate signals whose mean value follows a half sine. One triangular counter (8 bits by default) counts up to its maximum, then back down to zero, and serves both channels. A sequencer changes a duty value at a fixed dwell interval. It runs through four linear ramps in turn: a rise and a fall that feed channel A, then a rise and a fall that feed channel B. While one channel carries pulses, the other is held off.

Channel A compares its duty directly and is high while the counter is below it. Channel B takes the bitwise complement of the duty as its compare value and is high while the counter is above it, so both channels give the same pulse width for the same duty. Compare values are staged and take effect only when the counter is at its maximum, so no partial pulse appears. The dwell interval is set by a clock frequency and a dwell time in microseconds. A half-cycle flag tells the rest of the chip which channel the sequencer is feeding.

Top module: `spwm_halfcycle_gen`

## Requirements
- R1: While rst_ni is low, pwm_a_o, pwm_b_o and half_o are all 0, whatever en_i is. After release the counter starts at 0 and counts up, the sequencer starts on ramp 0 with duty 45, channel A's compare is 0 and channel B's compare is 255.
- R2: On every enabled clock the counter moves by exactly one step. It runs 0,1,…,255,254,…,1,0,1,… so one PWM frame is 510 enabled cycles.
- R3: Each duty value is held for DWELL_CYC = (CLK_FREQ_HZ/1,000,000)·DWELL_US enabled cycles. With en_i high from release, half_o is 0 after 124·DWELL_CYC−1 edges and 1 after 124·DWELL_CYC edges.
- R4: Ramp 0 (channel A rising) produces duty 45, 48, …, 237, which is 65 values. The next step would reach 240, so the sequencer moves to ramp 1.
- R5: Ramp 1 (channel A falling) produces 220, 217, …, 46, which is 59 values. The sequencer then moves to ramp 2.
- R6: Ramp 2 (channel B rising) produces 45, 48, …, 219. Ramp 3 (channel B falling) produces 220, …, 46. Each has 59 values. After ramp 3 the sequencer wraps to ramp 0, giving 242 steps per output period.
- R7: pwm_a_o is high exactly when en_i is high and counter < compare A. Compare A equals the duty during ramps 0 and 1 and is 0 during ramps 2 and 3.
- R8: pwm_b_o is high exactly when en_i is high and counter > compare B. Compare B equals 255 during ramps 0 and 1 and equals 255 − duty (the bitwise inverse) during ramps 2 and 3.
- R9: Compare A and compare B are loaded from the sequencer only on an enabled cycle in which the counter is 255. At all other times they hold their values.
- R10: half_o is 1 while the sequencer is in ramp 2 or ramp 3 and 0 otherwise. It changes only on a dwell step.
- R11: While en_i is low the counter, the dwell timer, the sequencer and the compare values all hold, and both PWM outputs are 0.
- R12: pwm_a_o and pwm_b_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low freezes the block and silences both outputs |
| pwm_a_o | output | 1 | Gate pulses for the positive half (non-inverting compare) |
| pwm_b_o | output | 1 | Gate pulses for the negative half (inverting compare) |
| half_o | output | 1 | 1 while the sequencer feeds channel B |

## Verification
With en_i held high, the first run shows the ramp lengths and the point where the halves swap. The edge-exact half_o check separates a dwell count that is one cycle off from an off-by-one step count in ramps 0 and 1. A long stretch with en_i low shows whether any state moves during a freeze. Randomly gated enable, with about one cycle in eight disabled, lands compare loads and dwell steps at many different counter phases. A per-cycle comparison of both outputs against a bench model then exposes a compare that is loaded away from the counter maximum, a wrong ramp boundary or a wrong inversion on channel B. A second reset in mid-run checks that every piece of state returns to its starting point.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  typedef enum logic [1:0] {
    RAMP_UP_A = 2'd0,
    RAMP_DN_A = 2'd1,
    RAMP_UP_B = 2'd2,
    RAMP_DN_B = 2'd3
  } ramp_e;
endpackage

// File: rtl/spwm_dwell_tick.sv
module spwm_dwell_tick #(
  parameter int DWELL_CYC = 6300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  generate
    if (DWELL_CYC <= 1) begin : g_every
      assign tick_o = en_i;
    end else begin : g_div
      localparam int W = $clog2(DWELL_CYC);
      localparam logic [W-1:0] LAST = W'(DWELL_CYC - 1);
      logic [W-1:0] q_q;

      assign tick_o = en_i && (q_q == LAST);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     q_q <= '0;
        else if (tick_o) q_q <= '0;
        else if (en_i)   q_q <= q_q + 1'b1;
      end

      p_tick_spacing_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
      p_freeze_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(q_q));
    end
  endgenerate
endmodule

// File: rtl/spwm_duty_seq.sv
module spwm_duty_seq
  import spwm_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int DUTY_LO = 45,
  parameter int STEP    = 3,
  parameter int TOP_A   = 240,
  parameter int FALL_HI = 220,
  parameter int TOP_B   = 220
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output ramp_e            ramp_o,
  output logic [CNT_W-1:0] duty_o
);
  localparam int NW = CNT_W + 1;
  localparam logic [NW-1:0] LO_N    = NW'(DUTY_LO);
  localparam logic [NW-1:0] STEP_N  = NW'(STEP);
  localparam logic [NW-1:0] TOPA_N  = NW'(TOP_A);
  localparam logic [NW-1:0] TOPB_N  = NW'(TOP_B);
  localparam logic [CNT_W-1:0] LO_D = CNT_W'(DUTY_LO);
  localparam logic [CNT_W-1:0] HI_D = CNT_W'(FALL_HI);

  ramp_e            ramp_q, ramp_d;
  logic [CNT_W-1:0] duty_q, duty_d;
  logic [NW-1:0]    up_n, dn_n;

  assign up_n = {1'b0, duty_q} + STEP_N;
  assign dn_n = {1'b0, duty_q} - STEP_N;

  always_comb begin
    ramp_d = ramp_q;
    duty_d = duty_q;
    if (tick_i) begin
      unique case (ramp_q)
        RAMP_UP_A: if (up_n < TOPA_N)  duty_d = up_n[CNT_W-1:0];
                   else begin ramp_d = RAMP_DN_A; duty_d = HI_D; end
        RAMP_DN_A: if (dn_n > LO_N)    duty_d = dn_n[CNT_W-1:0];
                   else begin ramp_d = RAMP_UP_B; duty_d = LO_D; end
        RAMP_UP_B: if (up_n <= TOPB_N) duty_d = up_n[CNT_W-1:0];
                   else begin ramp_d = RAMP_DN_B; duty_d = HI_D; end
        RAMP_DN_B: if (dn_n >= LO_N)   duty_d = dn_n[CNT_W-1:0];
                   else begin ramp_d = RAMP_UP_A; duty_d = LO_D; end
        default: begin ramp_d = RAMP_UP_A; duty_d = LO_D; end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ramp_q <= RAMP_UP_A;
      duty_q <= LO_D;
    end else begin
      ramp_q <= ramp_d;
      duty_q <= duty_d;
    end
  end

  assign ramp_o = ramp_q;
  assign duty_o = duty_q;

  p_duty_floor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_q >= LO_D);
  p_seq_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(duty_q) && $stable(ramp_q));
  p_a_turn_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && ramp_q == RAMP_UP_A) |=>
      (ramp_q == RAMP_UP_A) || (ramp_q == RAMP_DN_A && duty_q == HI_D));
  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && ramp_q == RAMP_DN_B) |=>
      (ramp_q == RAMP_DN_B) || (ramp_q == RAMP_UP_A && duty_q == LO_D));
endmodule

// File: rtl/spwm_pc_counter.sv
module spwm_pc_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic [CNT_W-1:0] cmp_b_i,
  output logic             pwm_a_o,
  output logic             pwm_b_o
);
  localparam logic [CNT_W-1:0] MAX = '1;

  logic [CNT_W-1:0] cnt_q, cmp_a_q, cmp_b_q;
  logic             down_q;
  logic             at_top;

  assign at_top = en_i && (cnt_q == MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      down_q  <= 1'b0;
      cmp_a_q <= '0;
      cmp_b_q <= MAX;
    end else if (en_i) begin
      // staged compares take effect only at the top of the triangle
      if (at_top) begin
        cmp_a_q <= cmp_a_i;
        cmp_b_q <= cmp_b_i;
      end
      if (!down_q) begin
        if (cnt_q == MAX) begin down_q <= 1'b1; cnt_q <= cnt_q - 1'b1; end
        else cnt_q <= cnt_q + 1'b1;
      end else begin
        if (cnt_q == '0) begin down_q <= 1'b0; cnt_q <= cnt_q + 1'b1; end
        else cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign pwm_a_o = en_i && (cnt_q < cmp_a_q);
  assign pwm_b_o = en_i && (cnt_q > cmp_b_q);

  p_cnt_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1));
  p_freeze_cnt_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q) && $stable(down_q));
  p_cmp_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !at_top |=> $stable(cmp_a_q) && $stable(cmp_b_q));
  p_no_overlap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pwm_a_o && pwm_b_o));
  p_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !pwm_a_o && !pwm_b_o);
endmodule

// File: rtl/spwm_halfcycle_gen.sv
module spwm_halfcycle_gen
  import spwm_pkg::*;
#(
  parameter int CLK_FREQ_HZ  = 100_000_000,
  parameter int DWELL_US     = 63,
  parameter int CNT_W        = 8,
  parameter int DUTY_LO      = 45,
  parameter int DUTY_STEP    = 3,
  parameter int RISE_A_LIMIT = 240,
  parameter int FALL_START   = 220,
  parameter int RISE_B_LIMIT = 220
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic pwm_a_o,
  output logic pwm_b_o,
  output logic half_o
);
  localparam int DWELL_CYC = (CLK_FREQ_HZ / 1_000_000) * DWELL_US;

  logic             tick;
  ramp_e            ramp;
  logic [CNT_W-1:0] duty;
  logic             b_half;
  logic [CNT_W-1:0] cmp_a_nxt, cmp_b_nxt;

  spwm_dwell_tick #(.DWELL_CYC(DWELL_CYC)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .tick_o(tick)
  );

  spwm_duty_seq #(
    .CNT_W  (CNT_W),
    .DUTY_LO(DUTY_LO),
    .STEP   (DUTY_STEP),
    .TOP_A  (RISE_A_LIMIT),
    .FALL_HI(FALL_START),
    .TOP_B  (RISE_B_LIMIT)
  ) u_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .ramp_o(ramp),
    .duty_o(duty)
  );

  assign b_half    = (ramp == RAMP_UP_B) || (ramp == RAMP_DN_B);
  assign cmp_a_nxt = b_half ? '0 : duty;
  assign cmp_b_nxt = b_half ? ~duty : '1;

  spwm_pc_counter #(.CNT_W(CNT_W)) u_pwm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .cmp_a_i(cmp_a_nxt),
    .cmp_b_i(cmp_b_nxt),
    .pwm_a_o(pwm_a_o),
    .pwm_b_o(pwm_b_o)
  );

  assign half_o = b_half;

  p_half_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(half_o));
endmodule

// File: tb/spwm_halfcycle_gen_bench.sv
module spwm_halfcycle_gen_bench;
  localparam int DW = 3;
  localparam int PERIOD_STEPS = 242;

  logic clk = 1'b0;
  logic rst_ni, en_i;
  logic pwm_a, pwm_b, half;
  int   total = 0, bad = 0;
  bit   done = 1'b0;

  int m_cnt, m_down, m_ma, m_mb, m_idx, m_q;

  always #5 clk = ~clk;

  spwm_halfcycle_gen #(.CLK_FREQ_HZ(1_000_000), .DWELL_US(DW)) u_spwm_halfcycle_gen (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .pwm_a_o(pwm_a),
    .pwm_b_o(pwm_b),
    .half_o (half)
  );

  // R4 R5 R6: duty sequence over one output period
  function automatic int duty_of(int i);
    if (i < 65)       return 45 + 3 * i;
    else if (i < 124) return 220 - 3 * (i - 65);
    else if (i < 183) return 45 + 3 * (i - 124);
    else              return 220 - 3 * (i - 183);
  endfunction

  function automatic bit bhalf_of(int i);
    return i >= 124;
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_down = 0; m_ma = 0; m_mb = 255; m_idx = 0; m_q = 0;
  endtask

  // R2 R3 R9 model, applied per enabled edge with pre-edge values
  task automatic model_step(input logic en);
    if (!en) return;
    if (m_cnt == 255) begin
      if (bhalf_of(m_idx)) begin m_ma = 0; m_mb = 255 - duty_of(m_idx); end
      else begin m_ma = duty_of(m_idx); m_mb = 255; end
    end
    if (m_down == 0) begin
      if (m_cnt == 255) begin m_down = 1; m_cnt = 254; end else m_cnt++;
    end else begin
      if (m_cnt == 0) begin m_down = 0; m_cnt = 1; end else m_cnt--;
    end
    if (m_q == DW - 1) begin m_q = 0; m_idx = (m_idx + 1) % PERIOD_STEPS; end
    else m_q++;
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  task automatic check_outputs();
    logic ea, eb;
    ea = en_i && (m_cnt < m_ma);
    eb = en_i && (m_cnt > m_mb);
    check_bit(en_i ? "R7 pwm_a (R2 R4 R5 R9)" : "R11 pwm_a", pwm_a, ea);
    check_bit(en_i ? "R8 pwm_b (R6 R9)" : "R11 pwm_b", pwm_b, eb);
    check_bit("R10 half", half, logic'(bhalf_of(m_idx)));
    check_bit("R12 overlap", logic'(pwm_a && pwm_b), 1'b0);
  endtask

  task automatic run_cycle(input logic en);
    en_i = en;
    @(posedge clk);
    model_step(en);
    @(negedge clk);
    check_outputs();
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    en_i   = 1'b1;
    repeat (3) @(negedge clk);
    check_bit("R1 pwm_a", pwm_a, 1'b0);
    check_bit("R1 pwm_b", pwm_b, 1'b0);
    check_bit("R1 half", half, 1'b0);
    en_i = 1'b0;
    @(negedge clk);
    check_bit("R1 quiet", logic'(pwm_a | pwm_b | half), 1'b0);
    model_reset();
    rst_ni = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd7));
    en_i = 1'b0;
    do_reset();

    // directed: continuous enable, half swap at exact edge
    for (int e = 1; e <= 2000; e++) begin
      run_cycle(1'b1);
      if (e == 124 * DW - 1) check_bit("R3 half before swap", half, 1'b0);
      if (e == 124 * DW)     check_bit("R5 half after swap", half, 1'b1);
    end

    // directed: long freeze
    for (int e = 0; e < 300; e++) run_cycle(1'b0);

    // random enable gating
    for (int e = 0; e < 15000; e++) run_cycle(logic'(($urandom % 8) != 0));

    // mid-run reset
    do_reset();
    for (int e = 0; e < 1500; e++) run_cycle(1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule